// File: doc/BRIEF.md
# Flat Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address by reading one entry from a flat, tagless page table in memory. The table begins at an address held in a base register. The entry for a page sits at that base plus four times the virtual page number, since each entry is one 32-bit word. The walker issues a single word read on a request/acknowledge memory port. It then either returns the physical address or reports a page fault.

The walker also keeps the usage flags of each entry. Every access to a valid page sets the entry's reference flag. Every store sets its modified flag. Each entry is kept with a read-modify-write, and the write is issued only when the stored word actually changes. An entry that is not valid is never written.

Entry layout: bit 31 is valid, bit 30 is modified (dirty), bit 29 is referenced, and bits 17:0 hold the physical page number. Bits 28:18 are reserved and should be zero.

A caller raises `req` with `vaddr` and `is_write`. It then waits for a one-cycle `done` pulse, which carries `fault` and `paddr`. The base register is loaded through its own write port.

Top module: `pt_walker`

## Requirements
- R1: After reset, `done`, `fault` and `mem_req` are 0.
- R2: The entry read uses `mem_addr` = base + `vaddr[31:12]`×4 with `mem_we` = 0. `mem_req` and `mem_addr` are held until `mem_ack`.
- R3: For a valid entry (bit 31 = 1), `done` pulses for one cycle. During that pulse `fault` = 0 and `paddr` = {entry[17:0], `vaddr[11:0]`}.
- R4: For an entry with bit 31 = 0, `done` pulses with `fault` = 1 and `paddr` = 0, and no write to memory is issued.
- R5: A valid entry with bit 29 = 0 is written back at the same address with bit 29 set.
- R6: A store to a valid page whose bit 30 is 0 writes the entry back with bit 30 set. A load leaves bit 30 unchanged.
- R7: A valid entry whose write-back would not change it gets no write. This means bit 29 = 1, bit 28:18 = 0, and either a load or bit 30 = 1.
- R8: A valid entry with any of bits 28:18 set is written back with those bits cleared. The reserved bits never affect `paddr`.
- R9: A base load while a walk is in progress applies only after that walk's `done`. A load while idle applies to the next walk.
- R10: `req` is accepted only when idle. A request raised during a walk produces no extra `done`.
- R11: When memory acknowledges one cycle after each request, `done` comes 3 cycles after the accepting edge without a write-back, and 5 cycles after it with one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a translation (taken when idle) |
| is_write | input | 1 | Access is a store |
| vaddr | input | 32 | Virtual address |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Page fault, valid with `done` |
| paddr | output | 30 | Physical address, valid with `done` |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 32 | New table base value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Entry value read |

## Verification
The bench memory acknowledges each request one cycle after it sees it. Under that memory, a walk without a write-back finishes 3 cycles after the edge that accepts the request, and a walk with a write-back finishes 5 cycles after it.

The driver records the cycle of acceptance and pushes the expected latency, fault, address, final entry word and write count into a queue. A monitor samples at falling edges and pops one item on each `done`. It compares the measured distance against the expected latency, so a result that arrives early or late fails even when its value is right.

Table contents and write counts are read on the `done` cycle. Any write-back has already landed by then.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 18,
  parameter int AW    = 32,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int EW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            is_write,
  input  logic [VA_W-1:0] vaddr,
  output logic            done,
  output logic            fault,
  output logic [PA_W-1:0] paddr,
  input  logic            base_we,
  input  logic [AW-1:0]   base_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [EW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [EW-1:0]   mem_rdata
);
  localparam int VB = EW - 1;
  localparam int DB = EW - 2;
  localparam int RB = EW - 3;

  typedef enum logic [2:0] {IDLE, READ_PTE, CHECK, WRITE_PTE, DONE} st_t;

  st_t             st;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic [EW-1:0]   pte_q;
  logic [AW-1:0]   base_q, pend_q;
  logic            pend_v;

  wire vld     = pte_q[VB];
  wire rsv_nz  = |pte_q[RB-1:PPN_W];
  wire need_wb = vld & (~pte_q[RB] | (wr_q & ~pte_q[DB]) | rsv_nz);

  assign mem_req   = (st == READ_PTE) || (st == WRITE_PTE);
  assign mem_we    = (st == WRITE_PTE);
  assign mem_addr  = base_q + {{(AW-VPN_W-2){1'b0}}, va_q[VA_W-1:OFF_W], 2'b00};
  assign mem_wdata = {1'b1, pte_q[DB] | wr_q, 1'b1, {(RB-PPN_W){1'b0}}, pte_q[PPN_W-1:0]};

  assign done  = (st == DONE);
  assign fault = done & ~vld;
  assign paddr = (done & vld) ? {pte_q[PPN_W-1:0], va_q[OFF_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      va_q  <= '0;
      wr_q  <= 1'b0;
      pte_q <= '0;
    end else begin
      case (st)
        IDLE:
          if (req) begin
            va_q <= vaddr;
            wr_q <= is_write;
            st   <= READ_PTE;
          end
        READ_PTE:
          if (mem_ack) begin
            pte_q <= mem_rdata;
            st    <= CHECK;
          end
        CHECK:     st <= need_wb ? WRITE_PTE : DONE;
        WRITE_PTE: if (mem_ack) st <= DONE;
        default:   st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (st == DONE) begin
      if (base_we)     base_q <= base_wdata;
      else if (pend_v) base_q <= pend_q;
      pend_v <= 1'b0;
    end else if (base_we) begin
      if (st == IDLE) base_q <= base_wdata;
      else begin
        pend_q <= base_wdata;
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 30,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] paddr,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [AW-1:0]   mem_addr
);
  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_fault_no_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && paddr == '0));

  a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r10_quiet_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_ack, 2));

  a_r2_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .fault(fault), .paddr(paddr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, is_write = 0, base_we = 0;
  logic [31:0] vaddr = 0, base_wdata = 0;
  logic        done, fault, mem_req, mem_we;
  logic [29:0] paddr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        mem_ack = 0;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req(req), .is_write(is_write), .vaddr(vaddr),
    .done(done), .fault(fault), .paddr(paddr), .base_we(base_we),
    .base_wdata(base_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  logic [31:0] mem [0:1023];
  int cyc = 0, wr_cnt = 0, n_chk = 0, n_fail = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else mem_rdata <= mem[mem_addr[11:2]];
    end else mem_ack <= 1'b0;
  end

  typedef struct {
    string       tag;
    int          t0;
    int          lat;
    logic        flt;
    logic [29:0] pa;
    int          idx;
    logic [31:0] ent;
    int          nwr;
  } exp_t;
  exp_t q[$];
  int extra_done = 0;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        extra_done++;
        chk("R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " latency R11"}, cyc - e.t0, e.lat);
        chk({e.tag, " fault R3/R4"}, fault, e.flt);
        chk({e.tag, " paddr R3"}, paddr, e.pa);
        chk({e.tag, " entry R5/R6/R8"}, mem[e.idx], e.ent);
        chk({e.tag, " writes R7"}, wr_cnt, e.nwr);
      end
    end
  end

  logic [31:0] eb = 0;

  task automatic walk(string tag, logic [19:0] vpn, logic [11:0] off, logic w,
                      logic mid_base = 0, logic [31:0] nb = 0, logic mid_req = 0);
    exp_t e;
    logic [31:0] a, ent;
    logic        wb;
    a     = eb + {10'd0, vpn, 2'b00};
    ent   = mem[a[11:2]];
    wb    = ent[31] && (!ent[29] || (w && !ent[30]) || ent[28:18] != 0);
    e.tag = tag;
    e.idx = int'(a[11:2]);
    e.flt = !ent[31];
    e.pa  = ent[31] ? {ent[17:0], off} : 30'd0;
    e.ent = wb ? {1'b1, ent[30] | w, 1'b1, 11'd0, ent[17:0]} : ent;
    e.nwr = wb ? 1 : 0;
    e.lat = wb ? 5 : 3;
    @(negedge clk);
    wr_cnt   = 0;
    req      = 1;
    is_write = w;
    vaddr    = {vpn, off};
    @(posedge clk);
    @(negedge clk);
    req  = 0;
    e.t0 = cyc;
    q.push_back(e);
    if (mid_base) begin
      base_we = 1; base_wdata = nb;
    end
    if (mid_req) begin
      req = 1; vaddr = 32'h0000_7123; is_write = 0;
    end
    @(negedge clk);
    base_we = 0;
    req     = 0;
    if (mid_base) eb = nb;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    mem[5]    = {3'b100, 11'd0, 18'h12345};
    mem[7]    = {3'b001, 11'd0, 18'h00aaa};
    mem[9]    = {3'b101, 11'd0, 18'h00042};
    mem[1023] = {3'b111, 11'd0, 18'h3ffff};
    mem[11]   = {3'b111, 11'h5a5, 18'h00777};
    mem[3]    = {3'b111, 11'd0, 18'h00111};
    mem[515]  = {3'b111, 11'd0, 18'h00222};
    repeat (3) @(negedge clk);
    chk("R1 done at reset", done, 0);
    chk("R1 fault at reset", fault, 0);
    chk("R1 mem_req at reset", mem_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {done, mem_req}, 0);

    walk("R5 first load", 20'd5, 12'h0a4, 0);
    walk("R7 repeat load", 20'd5, 12'h001, 0);
    walk("R6 first store", 20'd5, 12'hff0, 1);
    walk("R7 repeat store", 20'd5, 12'h010, 1);
    walk("R4 invalid load", 20'd7, 12'h123, 0);
    walk("R4 invalid store", 20'd7, 12'h456, 1);
    walk("R6 store sets dirty", 20'd9, 12'h800, 1);
    walk("R2 top page", 20'hfffff, 12'hfff, 0);
    walk("R8 reserved scrub", 20'd11, 12'h321, 0);
    walk("R9 deferred base", 20'd3, 12'h004, 0, 1, 32'h0000_0800);
    walk("R9 new base", 20'd3, 12'h008, 0);
    @(negedge clk);
    base_we = 1; base_wdata = 32'h0; eb = 32'h0;
    @(negedge clk);
    base_we = 0;
    walk("R9 idle base load", 20'd3, 12'h00c, 0);
    walk("R10 busy req", 20'd5, 12'h0bc, 0, 0, 0, 1);
    repeat (12) @(negedge clk);
    chk("R10 no extra done", extra_done, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule